// File: doc/BRIEF.md
# Capture Timer with Level-Split Overflow

An 8-bit up-counting timer driven by one of four prescaled count enables taken from a free-running divider of the system clock. An 8-bit mode register sets the count rate, the policy for clearing the counter from edges on the capture pin, the edge that raises a capture request, and whether overflow raises the interrupt line. The same register holds two overflow flags.

When the counter wraps, one of the two flags is set. Which one depends on the synchronized level of the capture pin at that moment, or on whether the timer runs with no clear policy (interval operation). Software cannot set a flag. It clears a flag by first reading the register with that flag at 1 and then writing 0 to that bit. The block sits on a simple register bus with two addresses: the mode register at address 0 and the read-only counter at address 1.

Top module: `capture_timer`

## Requirements
- R1: After reset the mode register reads 0x00, the counter reads 0x00, and irq and cap_req are low.
- R2: A write to address 0 loads bits 5:0 of the mode register from the write data: bit 5 overflow interrupt enable, bit 4 capture edge select, bits 3:2 clear policy, bits 1:0 rate select. Reads of address 0 return the register and reads of address 1 return the counter. Writes to address 1 are ignored.
- R3: The counter advances by one once every 8192, 2048, 128 or 32 system clocks for rate select 00, 01, 10 or 11. The divider runs freely from reset, so a window of N clocks holds exactly N/divisor advances whenever N is a multiple of the divisor.
- R4: An overflow is an advance from 0xFF, after which the counter reads 0x00.
- R5: An overflow while the clear policy is not 00 and the synchronized capture level is high sets bit 7 and leaves bit 6 unchanged.
- R6: An overflow while the synchronized capture level is low, or while the clear policy is 00, sets bit 6 and leaves bit 7 unchanged.
- R7: Writing 1 to bit 7 or bit 6 never changes that bit.
- R8: Writing 0 to bit 7 or bit 6 clears it only if a bus read of address 0 (read strobe high) returned that bit as 1 since the last clear attempt on that bit. Any such clear attempt uses up that read.
- R9: If an overflow sets a flag in the same cycle that a valid clear attempt hits it, the flag stays 1.
- R10: irq is high exactly while bit 5 is 1 and bit 7 or bit 6 is 1.
- R11: The capture pin passes through two synchronizing flip-flops. Clear policy 01 clears the counter on a falling edge, 10 on a rising edge, 11 on both, and 00 never. Clearing takes priority over an advance, and the counter reads 0x00 from the third clock edge after the pin changes.
- R12: cap_req pulses high for one cycle on the synchronized falling edge when bit 4 is 0, and on the synchronized rising edge when bit 4 is 1. It goes high after the second clock edge following the pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Register address: 0 mode, 1 counter |
| bus_rd | input | 1 | Read strobe; arms flag clearing |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| cap_pin | input | 1 | Asynchronous capture input |
| cap_req | output | 1 | One-cycle capture request on the selected edge |
| irq | output | 1 | Overflow interrupt request |

## Verification
Overflows are driven with the capture pin held high and held low under clear policies that leave the counter running. This separates the two flags, and interval operation shows that the pin level is ignored there. Clear attempts come without a prior read, after a read, and in the exact cycle of a hardware set, which separates the read-arming rule from set priority. Long random runs of pin toggles, reads and mode writes are compared every cycle against a bench model of the rate, clear and flag rules. Directed windows, timed from the pin change, pin down the divisor and the clear latency.

// File: rtl/ct_pkg.sv
package ct_pkg;

  // Mode register layout; bit positions are software visible.
  typedef struct packed {
    logic       ovf_hi;      // bit 7: overflow with capture level high
    logic       ovf_lo;      // bit 6: overflow with level low / interval
    logic       ovf_ie;      // bit 5
    logic       cap_rise;    // bit 4: 1 = rising capture request
    logic [1:0] clr_pol;     // bits 3:2
    logic [1:0] rate_sel;    // bits 1:0
  } mode_t;

  typedef enum logic [1:0] {
    CLR_NEVER = 2'b00,
    CLR_FALL  = 2'b01,
    CLR_RISE  = 2'b10,
    CLR_BOTH  = 2'b11
  } clr_pol_e;

  // Flag update: hardware set dominates a software clear.
  function automatic logic flag_next(input logic cur, input logic hw_set,
                                     input logic sw_clr);
    return hw_set | (cur & ~sw_clr);
  endfunction

  // Counter-clear decision from policy and synchronized edges.
  function automatic logic clear_hit(input logic [1:0] pol, input logic rise,
                                     input logic fall);
    return (pol[0] & fall) | (pol[1] & rise);
  endfunction

endpackage

// File: rtl/ct_prescale.sv
module ct_prescale #(
  parameter int LOG0 = 13,
  parameter int LOG1 = 11,
  parameter int LOG2 = 7,
  parameter int LOG3 = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int PRE_W = LOG0;

  logic [PRE_W-1:0] pre;
  logic [3:0]       taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;
  end

  for (genvar i = 0; i < 4; i++) begin : g_tap
    localparam int L = (i == 0) ? LOG0 : (i == 1) ? LOG1 : (i == 2) ? LOG2 : LOG3;
    assign taps[i] = &pre[L-1:0];
  end

  assign tick = taps[sel];

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/ct_capsync.sv
module ct_capsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], pin};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
  assign fall  = ~chain[STAGES-1] & chain[STAGES];

  // R11
  rise_from_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (level && !$past(level)));

  // R11
  fall_from_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> (!level && $past(level)));

endmodule

// File: rtl/ct_count.sv
module ct_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clr,
  output logic [W-1:0] count,
  output logic         ovf
);
  localparam logic [W-1:0] TOP = '1;

  assign ovf = tick & ~clr & (count == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (tick) count <= count + 1'b1;
  end

  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (count == '0));

  // R11
  clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  // R3
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(count));

endmodule

// File: rtl/ct_modereg.sv
module ct_modereg
  import ct_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_mode,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       set_hi,
  input  logic       set_lo,
  output mode_t      mode
);
  logic rd_mode, wr_mode;
  logic arm_hi, arm_lo;
  logic clr_hi, clr_lo;

  assign rd_mode = acc_mode & rd;
  assign wr_mode = acc_mode & wr;
  assign clr_hi  = wr_mode & ~wdata[7] & arm_hi;
  assign clr_lo  = wr_mode & ~wdata[6] & arm_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= '0;
      arm_hi <= 1'b0;
      arm_lo <= 1'b0;
    end else begin
      if (wr_mode) begin
        mode.ovf_ie   <= wdata[5];
        mode.cap_rise <= wdata[4];
        mode.clr_pol  <= wdata[3:2];
        mode.rate_sel <= wdata[1:0];
      end
      mode.ovf_hi <= flag_next(mode.ovf_hi, set_hi, clr_hi);
      mode.ovf_lo <= flag_next(mode.ovf_lo, set_lo, clr_lo);
      if (clr_hi)                        arm_hi <= 1'b0;
      else if (rd_mode && mode.ovf_hi)   arm_hi <= 1'b1;
      if (clr_lo)                        arm_lo <= 1'b0;
      else if (rd_mode && mode.ovf_lo)   arm_lo <= 1'b1;
    end
  end

  // R7
  hi_set_by_hw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode.ovf_hi) |-> $past(set_hi));

  // R7
  lo_set_by_hw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode.ovf_lo) |-> $past(set_lo));

  // R8
  hi_clear_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode.ovf_hi) |-> $past(arm_hi && wr_mode && !wdata[7]));

  // R8
  lo_clear_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode.ovf_lo) |-> $past(arm_lo && wr_mode && !wdata[6]));

  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_lo && clr_lo) |=> mode.ovf_lo);

endmodule

// File: rtl/capture_timer.sv
module capture_timer
  import ct_pkg::*;
#(
  parameter int ADDR_W      = 1,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LOG_RATE0   = 13,
  parameter int LOG_RATE1   = 11,
  parameter int LOG_RATE2   = 7,
  parameter int LOG_RATE3   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              cap_pin,
  output logic              cap_req,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] MODE_ADDR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] COUNT_ADDR = ADDR_W'(1);

  mode_t            mode;
  logic             tick;
  logic             cap_level, cap_rise_ev, cap_fall_ev;
  logic             clr_ev, ovf_ev, interval_mode;
  logic             set_hi, set_lo;
  logic [CNT_W-1:0] count;

  ct_prescale #(
    .LOG0(LOG_RATE0), .LOG1(LOG_RATE1), .LOG2(LOG_RATE2), .LOG3(LOG_RATE3)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(mode.rate_sel), .tick(tick)
  );

  ct_capsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin),
    .level(cap_level), .rise(cap_rise_ev), .fall(cap_fall_ev)
  );

  assign clr_ev        = clear_hit(mode.clr_pol, cap_rise_ev, cap_fall_ev);
  assign interval_mode = (mode.clr_pol == CLR_NEVER);

  ct_count #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr_ev),
    .count(count), .ovf(ovf_ev)
  );

  assign set_hi = ovf_ev & ~interval_mode & cap_level;
  assign set_lo = ovf_ev & (interval_mode | ~cap_level);

  ct_modereg u_mode (
    .clk(clk), .rst_n(rst_n), .acc_mode(bus_addr == MODE_ADDR),
    .rd(bus_rd), .wr(bus_wr), .wdata(bus_wdata),
    .set_hi(set_hi), .set_lo(set_lo), .mode(mode)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == MODE_ADDR)       bus_rdata = mode;
    else if (bus_addr == COUNT_ADDR) bus_rdata = 8'(count);
  end

  assign cap_req = mode.cap_rise ? cap_rise_ev : cap_fall_ev;
  assign irq     = mode.ovf_ie & (mode.ovf_hi | mode.ovf_lo);

  // R5
  level_high_sets_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ev && !interval_mode && cap_level) |=> mode.ovf_hi);

  // R6
  interval_sets_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ev && interval_mode) |=> mode.ovf_lo);

endmodule

// File: tb/tb_capture_timer.sv
`timescale 1ns/1ps
module tb_capture_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       b_addr = 1'b0, b_rd = 1'b0, b_wr = 1'b0, b_pin = 1'b0;
  logic [7:0] b_wd = 8'h00;
  logic [7:0] rdata;
  logic       cap_req, irq;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  // reference state
  logic [7:0] m_mode, m_cnt;
  logic       m_s1, m_s2, m_d, m_ahi, m_alo;
  int         m_cyc;

  always #2.5 clk = ~clk;

  capture_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_rd(b_rd), .bus_wr(b_wr),
    .bus_wdata(b_wd), .bus_rdata(rdata), .cap_pin(b_pin), .cap_req(cap_req),
    .irq(irq)
  );

  function automatic int divisor(input logic [1:0] sel);
    case (sel)
      2'b00:   return 8192;
      2'b01:   return 2048;
      2'b10:   return 128;
      default: return 32;
    endcase
  endfunction

  function automatic logic exp_irq(input logic [7:0] m);
    return m[5] && (m[7] || m[6]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 8'h00; m_cnt = 8'h00; m_s1 = 0; m_s2 = 0; m_d = 0;
      m_ahi = 0; m_alo = 0; m_cyc = 0;
    end else begin
      logic tk, rs, fl, cl, ov, itv, sh, sl, wm, rm, ch, clo;
      logic [7:0] nm;
      tk  = (m_cyc % divisor(m_mode[1:0])) == divisor(m_mode[1:0]) - 1;
      rs  = m_s2 && !m_d;
      fl  = !m_s2 && m_d;
      cl  = (m_mode[2] && fl) || (m_mode[3] && rs);
      ov  = tk && !cl && (m_cnt == 8'hFF);
      itv = (m_mode[3:2] == 2'b00);
      sh  = ov && !itv && m_s2;
      sl  = ov && (itv || !m_s2);
      wm  = b_wr && (b_addr == 1'b0);
      rm  = b_rd && (b_addr == 1'b0);
      ch  = wm && !b_wd[7] && m_ahi;
      clo = wm && !b_wd[6] && m_alo;
      nm = m_mode;
      if (wm) nm[5:0] = b_wd[5:0];
      nm[7] = sh || (m_mode[7] && !ch);
      nm[6] = sl || (m_mode[6] && !clo);
      if (ch) m_ahi = 0; else if (rm && m_mode[7]) m_ahi = 1;
      if (clo) m_alo = 0; else if (rm && m_mode[6]) m_alo = 1;
      if (cl) m_cnt = 8'h00; else if (tk) m_cnt = m_cnt + 8'h01;
      m_mode = nm;
      m_d = m_s2; m_s2 = m_s1; m_s1 = b_pin;
      m_cyc++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // call at a falling edge: apply inputs, then compare against the model
  task automatic drive(input logic a, input logic rd, input logic wr, input logic [7:0] wd);
    b_addr = a; b_rd = rd; b_wr = wr; b_wd = wd;
    #1;
    chk(a ? "R3_R4_R11 count" : "R5_R6_R8 mode", rdata, a ? m_cnt : m_mode);
    chk("R10 irq", irq, exp_irq(m_mode));
    chk("R12 cap_req", cap_req, m_mode[4] ? (m_s2 && !m_d) : (!m_s2 && m_d));
  endtask

  task automatic cyc(input logic a, input logic rd, input logic wr, input logic [7:0] wd);
    @(negedge clk);
    drive(a, rd, wr, wd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic wait_flag(input int bitn);
    for (int i = 0; i < 20000 && !m_mode[bitn]; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] c0, c1;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cyc(1'b0, 0, 0, 8'h00); chk("R1 mode", rdata, 8'h00); chk("R1 irq", irq, 0);
    chk("R1 cap_req", cap_req, 0);
    cyc(1'b1, 0, 0, 8'h00); chk("R1 count", rdata, 8'h00);

    // R2 field write / readback, counter write ignored
    cyc(1'b0, 0, 1, 8'h1B); cyc(1'b0, 0, 0, 8'h00); chk("R2 readback", rdata, 8'h1B);
    cyc(1'b1, 0, 1, 8'h77); cyc(1'b1, 0, 0, 8'h00); chk("R2 count write ignored", rdata, m_cnt);

    // R3 divisor per rate select
    for (int s = 0; s < 4; s++) begin
      cyc(1'b0, 0, 1, 8'(s));
      cyc(1'b1, 0, 0, 8'h00); c0 = rdata;
      idle(3 * divisor(2'(s)));
      c1 = rdata;
      chk("R3 advances in window", 32'(8'(c1 - c0)), 32'd3);
    end

    // R6 interval operation ignores a high pin; R10 irq
    b_pin = 1'b1;
    cyc(1'b0, 0, 1, 8'h23);
    wait_flag(6);
    cyc(1'b0, 0, 0, 8'h00); chk("R6 interval sets low flag", rdata[7:6], 2'b01);
    chk("R10 irq with enable", irq, 1);

    // R7 writing ones to flags; R10 enable off masks irq
    cyc(1'b0, 0, 1, 8'hC3); cyc(1'b0, 0, 0, 8'h00);
    chk("R7 ones leave flags", rdata, 8'h43);
    chk("R10 irq masked", irq, 0);

    // R8 clear without prior read has no effect, then read-then-clear
    cyc(1'b0, 0, 1, 8'h23); cyc(1'b0, 0, 0, 8'h00); chk("R8 unarmed clear", rdata, 8'h63);
    cyc(1'b0, 1, 0, 8'h00); cyc(1'b0, 0, 1, 8'h23); cyc(1'b0, 0, 0, 8'h00);
    chk("R8 armed clear", rdata, 8'h23);
    chk("R10 irq drops", irq, 0);

    // R5 high level with falling-clear policy
    cyc(1'b0, 0, 1, 8'h27);
    wait_flag(7);
    cyc(1'b0, 0, 0, 8'h00); chk("R5 high level sets high flag", rdata[7:6], 2'b10);
    cyc(1'b0, 1, 0, 8'h00); cyc(1'b0, 0, 1, 8'h2B); cyc(1'b0, 0, 0, 8'h00);
    chk("R8 clear high flag", rdata, 8'h2B);

    // R6 low level with rising-clear policy
    b_pin = 1'b0;
    wait_flag(6);
    cyc(1'b0, 0, 0, 8'h00); chk("R6 low level sets low flag", rdata[7:6], 2'b01);

    // R9 set and clear in the same cycle
    cyc(1'b0, 1, 0, 8'h00);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (m_cnt == 8'hFF && (m_cyc % 32) == 31) begin
        drive(1'b0, 0, 1, 8'h2B);
        break;
      end
      drive(1'b1, 0, 0, 8'h00);
    end
    cyc(1'b0, 0, 0, 8'h00); chk("R9 set wins", rdata[6], 1'b1);
    cyc(1'b0, 0, 1, 8'h2B); cyc(1'b0, 0, 0, 8'h00); chk("R8 read consumed", rdata[6], 1'b1);
    cyc(1'b0, 1, 0, 8'h00); cyc(1'b0, 0, 1, 8'h1B); cyc(1'b0, 0, 0, 8'h00);
    chk("R8 clear after reread", rdata, 8'h1B);

    // R11 clear on rising edge with latency, R12 rising request
    idle(70);
    @(negedge clk); b_pin = 1'b1; drive(1'b1, 0, 0, 8'h00);
    cyc(1'b1, 0, 0, 8'h00);
    cyc(1'b1, 0, 0, 8'h00); chk("R12 rising request", cap_req, 1);
    chk("R11 not yet cleared", rdata != 8'h00, 1);
    cyc(1'b1, 0, 0, 8'h00); chk("R11 cleared on rise", rdata, 8'h00);
    // falling edge under rising-only policy: no clear, no rising request
    idle(70);
    @(negedge clk); b_pin = 1'b0; drive(1'b1, 0, 0, 8'h00);
    cyc(1'b1, 0, 0, 8'h00);
    cyc(1'b1, 0, 0, 8'h00); chk("R12 falling ignored", cap_req, 0);
    cyc(1'b1, 0, 0, 8'h00); chk("R11 fall ignored", rdata != 8'h00, 1);

    // random phase checked against the model each cycle
    for (int i = 0; i < 60000; i++) begin
      int r;
      r = int'($urandom % 1000);
      if (r < 6) b_pin = ~b_pin;
      @(negedge clk);
      if (r >= 10 && r < 30)      drive(1'b0, 1, 0, 8'h00);
      else if (r >= 30 && r < 34) drive(1'b0, 0, 1, 8'($urandom) | 8'h02);
      else if (r >= 34 && r < 40) drive(1'b1, 0, 1, 8'($urandom));
      else if (r >= 40 && r < 46) drive(1'b0, $urandom % 2 == 0, 1, {2'(0), 6'($urandom)} | 8'h03);
      else                        drive(1'($urandom % 2), 0, 0, 8'h00);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule